// File: doc/BRIEF.md
# Alternate-Byte Peripheral Data Mover

This block copies a 32-bit register value to, or fills it from, an 8-bit peripheral whose registers sit on every second byte address. A caller gives a base address, a signed 16-bit displacement, an operand size (16 or 32 bits) and a direction, then pulses start. The block adds the sign-extended displacement to the base and walks a byte-wide bus with a valid/ready handshake. It sends the most significant byte first and adds two to the address after every completed transfer.

For a write, the register bytes go out in turn on the bus. For a read, each returned byte is merged into the matching slice of the register. A word-size read leaves the upper half of the register as it was given at start. A one-cycle done pulse marks the end of the operation, and the final register value is valid in that same cycle. A start pulse that arrives while an operation is running is dropped.

Top module: `altbyte_mover`

## Requirements
- R1: The first transfer address equals `base_i` plus `disp_i` sign-extended to 32 bits, with the sum taken modulo 2^32.
- R2: Each later transfer address is the previous address plus 2.
- R3: In a 32-bit write (`size_long_i`=1, `dir_read_i`=0), the bytes sent are register bits 31:24, then 23:16, then 15:8, then 7:0.
- R4: A 16-bit operation (`size_long_i`=0) makes exactly 2 bus transfers. A 32-bit operation makes exactly 4.
- R5: `bus_write_o` is 1 for every transfer when `dir_read_i`=0 and 0 for every transfer when `dir_read_i`=1. In a 32-bit read, the n-th accepted byte (n counted from 0) lands in register bits 31-8n down to 24-8n.
- R6: In a 16-bit write, register bits 15:8 go out first and bits 7:0 second.
- R7: In a 16-bit read, the two bytes land in bits 15:8 and then 7:0, and `reg_o[31:16]` equals `reg_i[31:16]` as sampled at start.
- R8: At most one transfer is outstanding. While `bus_valid_o` is high and `bus_ready_i` is low, the valid, address and write data are held. The address advances only after a completed handshake.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last handshake. `reg_o` holds the final value in that cycle. No transfer is offered while `done_o` is high.
- R10: A start pulse given while `busy_o` is high, including the cycle in which `done_o` is high, causes no transfer. Inputs that change after start has been accepted do not affect the operation.
- R11: After reset, `busy_o`, `done_o` and `bus_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| dir_read_i | input | 1 | 1 = bus to register, 0 = register to bus |
| size_long_i | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| base_i | input | 32 | Base address |
| disp_i | input | 16 | Signed displacement |
| reg_i | input | 32 | Register value sampled at start |
| busy_o | output | 1 | Operation in progress (includes the done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| reg_o | output | 32 | Register value, final when done_o is high |
| bus_valid_o | output | 1 | Transfer request |
| bus_ready_i | input | 1 | Transfer accepted |
| bus_write_o | output | 1 | 1 = write transfer |
| bus_addr_o | output | 32 | Byte address |
| bus_wdata_o | output | 8 | Write byte |
| bus_rdata_i | input | 8 | Read byte, taken on the handshake |

## Verification
A fresh start request can coincide with bus activity. It may arrive while transfers are still stalling or completing, or in the very cycle the done pulse is raised. The bench holds start high and changes the base, displacement, direction and register inputs from acceptance through the done cycle. Its scoreboard holds only the transfers of the accepted operation, so any extra or altered transfer appears as an unexpected or mismatched item. After the done cycle the bench also requires busy and valid to be low.

// File: rtl/altbyte_pkg.sv
package altbyte_pkg;

   // Sequencer phases: waiting, stepping through bytes, reporting completion
   typedef enum logic [1:0] {
      MV_IDLE = 2'd0,
      MV_XFER = 2'd1,
      MV_DONE = 2'd2
   } mv_state_e;

endpackage

// File: rtl/altbyte_seq.sv
module altbyte_seq
   import altbyte_pkg::*;
#(
   parameter int NBYTES = 4,
   parameter int CNT_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             long_i,
   input  logic             write_i,
   input  logic             hs_i,
   output logic             load_o,
   output logic             xfer_o,
   output logic             last_o,
   output logic             done_o,
   output logic             busy_o,
   output logic             write_o,
   output logic [CNT_W-1:0] lane_o
);
   localparam int HALF = NBYTES / 2;

   mv_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             long_q;
   logic             write_q;

   assign load_o  = start_i && (state_q == MV_IDLE);
   assign xfer_o  = (state_q == MV_XFER);
   assign done_o  = (state_q == MV_DONE);
   assign busy_o  = (state_q != MV_IDLE);
   assign write_o = write_q;
   assign last_o  = (cnt_q == (long_q ? CNT_W'(NBYTES - 1) : CNT_W'(HALF - 1)));
   // word operands use the low half of the register lanes
   assign lane_o  = long_q ? cnt_q : cnt_q + CNT_W'(HALF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         cnt_q   <= '0;
         long_q  <= 1'b0;
         write_q <= 1'b0;
      end else begin
         case (state_q)
            MV_IDLE: begin
               if (start_i) begin
                  state_q <= MV_XFER;
                  cnt_q   <= '0;
                  long_q  <= long_i;
                  write_q <= write_i;
               end
            end
            MV_XFER: begin
               if (hs_i) begin
                  if (last_o) state_q <= MV_DONE;
                  else        cnt_q   <= cnt_q + 1'b1;
               end
            end
            default: state_q <= MV_IDLE;
         endcase
      end
   end

   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: start while busy does not disturb the byte position
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !hs_i) |=> $stable(cnt_q));

endmodule

// File: rtl/altbyte_addr.sv
module altbyte_addr #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16,
   parameter int STRIDE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] addr_q;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_full
         assign disp_ext = disp_i[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= base_i + disp_ext;
      else if (step_i) addr_q <= addr_q + ADDR_W'(STRIDE);
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/altbyte_merge.sv
module altbyte_merge #(
   parameter int NBYTES = 4,
   parameter int LANE_W = 8,
   parameter int CNT_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [NBYTES*LANE_W-1:0] reg_i,
   input  logic                     rd_en_i,
   input  logic [CNT_W-1:0]         lane_i,
   input  logic [LANE_W-1:0]        rdata_i,
   output logic [NBYTES*LANE_W-1:0] reg_o,
   output logic [LANE_W-1:0]        wdata_o
);
   localparam int DATA_W = NBYTES * LANE_W;
   localparam int HALF   = NBYTES / 2;
   localparam int UPPER  = DATA_W / 2;

   // lane 0 is the most significant byte of the register
   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         localparam int LSB = (NBYTES - 1 - g) * LANE_W;
         logic [LANE_W-1:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (load_i)
               byte_q <= reg_i[LSB +: LANE_W];
            else if (rd_en_i && (lane_i == CNT_W'(g)))
               byte_q <= rdata_i;
         end
         assign reg_o[LSB +: LANE_W] = byte_q;
      end
   endgenerate

   always_comb begin
      wdata_o = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (lane_i == CNT_W'(i)) wdata_o = reg_o[(NBYTES - 1 - i) * LANE_W +: LANE_W];
      end
   end

   // R7: a byte arriving for a lower-half lane leaves the upper half untouched
   assert_word_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && rd_en_i && (lane_i >= CNT_W'(HALF)))
      |=> (reg_o[DATA_W-1 -: UPPER] == $past(reg_o[DATA_W-1 -: UPPER])));

endmodule

// File: rtl/altbyte_mover.sv
module altbyte_mover #(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 32,
   parameter int LANE_W = 8,
   parameter int DISP_W = 16,
   parameter int STRIDE = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_read_i,
   input  logic              size_long_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [REG_W-1:0]  reg_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [REG_W-1:0]  reg_o,
   output logic              bus_valid_o,
   input  logic              bus_ready_i,
   output logic              bus_write_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [LANE_W-1:0] bus_wdata_o,
   input  logic [LANE_W-1:0] bus_rdata_i
);
   localparam int NBYTES = REG_W / LANE_W;
   localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   initial begin
      assert (REG_W % LANE_W == 0) else $error("register width must be a whole number of lanes");
      assert (NBYTES >= 2 && NBYTES % 2 == 0) else $error("lane count must be even");
      assert (DISP_W <= ADDR_W) else $error("displacement wider than address");
      assert (STRIDE >= 1) else $error("stride must be positive");
   end

   logic             load;
   logic             xfer;
   logic             last;
   logic             hs;
   logic             write;
   logic [CNT_W-1:0] lane;

   assign hs          = xfer && bus_ready_i;
   assign bus_valid_o = xfer;
   assign bus_write_o = write;

   altbyte_seq #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .long_i  (size_long_i),
      .write_i (!dir_read_i),
      .hs_i    (hs),
      .load_o  (load),
      .xfer_o  (xfer),
      .last_o  (last),
      .done_o  (done_o),
      .busy_o  (busy_o),
      .write_o (write),
      .lane_o  (lane)
   );

   altbyte_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STRIDE(STRIDE)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (hs),
      .base_i (base_i),
      .disp_i (disp_i),
      .addr_o (bus_addr_o)
   );

   altbyte_merge #(.NBYTES(NBYTES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .reg_i   (reg_i),
      .rd_en_i (hs && !write),
      .lane_i  (lane),
      .rdata_i (bus_rdata_i),
      .reg_o   (reg_o),
      .wdata_o (bus_wdata_o)
   );

   // R8: a stalled request holds its address and data
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_o && !bus_ready_i)
      |=> (bus_valid_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

   // R2: an accepted byte that is not the last moves the address by the stride
   assert_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_o && bus_ready_i && !last)
      |=> (bus_valid_o && (bus_addr_o == $past(bus_addr_o) + ADDR_W'(STRIDE))));

   // R9: the done cycle offers no transfer and follows the final handshake
   assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bus_valid_o);

   assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid_o && bus_ready_i && last) |=> done_o);

endmodule

// File: tb/sim_altbyte_mover.sv
`timescale 1ns/1ps
module sim_altbyte_mover;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir_read = 1'b0;
   logic        size_long = 1'b0;
   logic [31:0] base = '0;
   logic [15:0] disp = '0;
   logic [31:0] regv = '0;
   logic        busy, done, valid, wr;
   logic        ready = 1'b0;
   logic [31:0] reg_out, addr;
   logic [7:0]  wdata, rdata;

   always #10 clk = ~clk;

   altbyte_mover u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dir_read_i(dir_read),
      .size_long_i(size_long), .base_i(base), .disp_i(disp), .reg_i(regv),
      .busy_o(busy), .done_o(done), .reg_o(reg_out), .bus_valid_o(valid),
      .bus_ready_i(ready), .bus_write_o(wr), .bus_addr_o(addr),
      .bus_wdata_o(wdata), .bus_rdata_i(rdata)
   );

   function automatic logic [7:0] peri_byte(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hC3;
   endfunction
   assign rdata = peri_byte(addr);

   typedef struct {
      logic [31:0] a;
      logic        w;
      logic [7:0]  d;
      bit          first;
      bit          lng;
   } beat_t;

   beat_t       exp_q[$];
   logic [31:0] rexp_q[$];
   string       rtag_q[$];

   int  checks = 0;
   int  fails  = 0;
   bit  always_rdy = 1'b1;
   bit  expect_done = 1'b0;
   bit  prev_wait = 1'b0;
   bit  finished = 1'b0;
   logic [31:0] prev_addr = '0;
   logic [7:0]  lfsr = 8'h5B;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops scoreboard items as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_wait)
            chk(valid && addr == prev_addr, "R8", "stalled request held", addr, prev_addr);
         if (done !== expect_done)
            chk(1'b0, "R9", "done timing", {31'b0, done}, {31'b0, expect_done});
         if (done) begin
            if (rexp_q.size() == 0) chk(1'b0, "R10", "done without operation", 32'h1, 32'h0);
            else begin
               logic [31:0] e;
               string t;
               e = rexp_q.pop_front();
               t = rtag_q.pop_front();
               chk(reg_out === e, t, "register at done", reg_out, e);
               chk(exp_q.size() == 0, "R4", "transfer count", exp_q.size(), 0);
            end
         end
         ready = always_rdy ? 1'b1 : (lfsr[0] | lfsr[3]);
         lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         expect_done = 1'b0;
         if (valid && ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R10", "unexpected transfer", addr, 32'h0);
            else begin
               beat_t b;
               b = exp_q.pop_front();
               chk(addr === b.a, b.first ? "R1" : "R2", "address", addr, b.a);
               chk(wr === b.w, "R5", "direction", {31'b0, wr}, {31'b0, b.w});
               if (b.w) chk(wdata === b.d, b.lng ? "R3" : "R6", "write byte", {24'b0, wdata}, {24'b0, b.d});
               expect_done = (exp_q.size() == 0);
            end
         end
         prev_wait = valid && !ready;
         prev_addr = addr;
      end
   end

   // driver: pushes expected items and starts one operation
   task automatic do_op(input bit rd, input bit lng, input logic [31:0] b,
                        input logic [15:0] d, input logic [31:0] r, input bit hammer);
      logic [31:0] a0, e;
      int n;
      a0 = b + {{16{d[15]}}, d};
      n = lng ? 4 : 2;
      e = r;
      for (int k = 0; k < n; k++) begin
         beat_t bt;
         int lane;
         lane = lng ? k : k + 2;
         bt.a = a0 + 32'(2 * k);
         bt.w = !rd;
         bt.d = r[(3 - lane) * 8 +: 8];
         bt.first = (k == 0);
         bt.lng = lng;
         if (rd) e[(3 - lane) * 8 +: 8] = peri_byte(bt.a);
         exp_q.push_back(bt);
      end
      rexp_q.push_back(e);
      rtag_q.push_back(rd ? (lng ? "R5" : "R7") : "R9");
      @(negedge clk);
      start = 1'b1; dir_read = rd; size_long = lng; base = b; disp = d; regv = r;
      @(negedge clk);
      if (!hammer) start = 1'b0;
      base = ~b; disp = ~d; regv = ~r; dir_read = !rd; size_long = !lng;
      while (!done) @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(!busy && !valid, "R10", "idle after done with start held",
          {30'b0, busy, valid}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !valid, "R11", "reset outputs", {29'b0, busy, done, valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      always_rdy = 1'b1;
      do_op(1'b0, 1'b1, 32'h0000_1000, 16'h0010, 32'hA1B2_C3D4, 1'b0);
      always_rdy = 1'b0;
      do_op(1'b0, 1'b1, 32'h0000_2000, 16'hFFF0, 32'h1122_3344, 1'b0);
      do_op(1'b0, 1'b0, 32'h8000_0000, 16'h0004, 32'hDEAD_BEEF, 1'b0);
      do_op(1'b1, 1'b1, 32'h0000_4400, 16'h0022, 32'h0000_0000, 1'b0);
      do_op(1'b1, 1'b0, 32'h0000_5500, 16'h8000, 32'hCAFE_F00D, 1'b0);
      do_op(1'b0, 1'b1, 32'h0000_FFFE, 16'h7FFF, 32'h0F1E_2D3C, 1'b1);
      always_rdy = 1'b1;
      do_op(1'b1, 1'b0, 32'hFFFF_FFFC, 16'h0002, 32'h7654_3210, 1'b1);
      do_op(1'b1, 1'b1, 32'h0000_0100, 16'h0000, 32'hFFFF_FFFF, 1'b1);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0 && rexp_q.size() == 0, "R4", "scoreboard drained",
          exp_q.size() + rexp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
      end
      $finish;
   end

endmodule